// File: doc/BRIEF.md
# Masked Vector Lane Extract Unit

This block copies one aligned slice out of a wide integer vector into the low part of a destination. The source is either 512 or 256 bits wide, and the slice is either 128 or 256 bits wide. The low bits of an 8-bit immediate choose which slice is taken. A per-element writemask then decides, for each element, whether that element receives the extracted data. An element is 32 or 64 bits wide. An element that is masked off either keeps the old destination value or becomes zero.

The destination can be a register or memory, and the two are handled differently.

- **Register destination:** the unit returns a full-width result in which everything above the slice is cleared. Every byte enable is set.
- **Memory destination:** zeroing never applies. The unit returns the slice together with a byte-enable vector that covers only the elements selected by the mask.

A check on the reserved encoding fields raises a fault flag. A faulting operation writes nothing.

The unit is a single registered stage with no handshake. An operation presented with `in_valid` appears on the outputs one clock later.

Top module: `vec_lane_extract`

## Requirements
- R1: With a 256-bit source (`src_wide`=0) and a 128-bit slice, `imm[0]`=0 returns source bits 127:0 and `imm[0]`=1 returns bits 255:128. `imm[7:1]` has no effect.
- R2: With a 512-bit source (`src_wide`=1) and a 128-bit slice (`slice_wide`=0), `imm[1:0]` values 0, 1, 2 and 3 return source bits 127:0, 255:128, 383:256 and 511:384. `imm[7:2]` has no effect.
- R3: With a 256-bit slice (`slice_wide`=1) from a 512-bit source, `imm[0]`=0 returns bits 255:0 and `imm[0]`=1 returns bits 511:256. `imm[7:1]` has no effect.
- R4: With `elem64`=0, 32-bit element j of the slice is controlled by `kmask[j]`. With `elem64`=1, 64-bit element j is controlled by `kmask[j]`. Mask bits beyond the slice's element count (4 or 8 for 32-bit elements, 2 or 4 for 64-bit elements) have no effect.
- R5: When `mask_en`=0, or when `legacy_enc`=1, every element of the slice receives the extracted data, whatever `kmask` holds.
- R6: For a register destination (`dst_mem`=0) with `zero_mode`=0, an element whose mask bit is clear takes the matching element of `old_low`.
- R7: For a register destination with `zero_mode`=1, an element whose mask bit is clear becomes zero.
- R8: For a register destination, `out_data` above the slice width is zero and all bits of `out_byte_en` are 1 (bit b enables byte b of `out_data`).
- R9: For a memory destination, `out_data` carries the unmasked slice in its low bits and zero above it. `out_byte_en` is 1 exactly on the bytes of the slice elements whose mask bit is set (or on all of them when masking is off). `zero_mode` has no effect.
- R10: `out_fault` is 1 when `rsv_spec` is not 4'b1111, when `legacy_enc`=1 with `vlen_bit`=0, or when a 256-bit slice is asked from a 256-bit source. Otherwise it is 0.
- R11: When `out_fault` is 1, `out_byte_en` is all zero.
- R12: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1. `out_data` and `out_byte_en` hold their values after a cycle without `in_valid`. A synchronous active-low reset clears `out_valid`, `out_fault`, `out_data` and `out_byte_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| src_wide | input | 1 | 1: 512-bit source, 0: 256-bit source (low half of `src_vec`) |
| slice_wide | input | 1 | 1: 256-bit slice, 0: 128-bit slice |
| elem64 | input | 1 | 1: 64-bit mask elements, 0: 32-bit |
| mask_en | input | 1 | Writemask active |
| zero_mode | input | 1 | Masked-off register elements are zeroed instead of merged |
| dst_mem | input | 1 | 1: memory destination, 0: register destination |
| legacy_enc | input | 1 | Legacy unmasked encoding |
| vlen_bit | input | 1 | Vector-length bit of the encoding |
| rsv_spec | input | 4 | Reserved register specifier, legal only as 4'b1111 |
| imm | input | 8 | Slice-select immediate |
| kmask | input | 8 | Per-element writemask |
| src_vec | input | 512 | Source vector |
| old_low | input | 256 | Previous low 256 bits of the register destination |
| out_valid | output | 1 | Result valid |
| out_fault | output | 1 | Illegal encoding detected |
| out_data | output | 512 | Result data |
| out_byte_en | output | 64 | Per-byte write enables |

## Verification
The bench first drives immediates whose ignored upper bits are set. A unit that decodes too many bits would then pick the wrong slice, or pick a slice outside a 256-bit source. It also gives masks with bits set above the slice's element count. A unit that mapped 64-bit elements onto 32-bit mask bits would then merge the wrong halves.

Memory operations run with zeroing requested. A unit that zeroed memory data, or that drove enables above the slice, would be caught there. Register operations check that upper bits are cleared and that all byte enables are set.

Each of the three fault causes is checked on its own, to catch a fault that leaves any byte enable set. An idle cycle after a valid one catches an output register that does not hold its value.

// File: rtl/vle_pkg.sv
// Package: default geometry of the lane extract unit.
// Assumes power-of-two widths with CHUNK_W a multiple of WORD_W.
package vle_pkg;
    localparam int VLE_VEC_W   = 512;  // widest source vector
    localparam int VLE_CHUNK_W = 128;  // narrow slice width
    localparam int VLE_WORD_W  = 32;   // smallest mask element
    localparam int VLE_MASK_W  = 8;    // writemask bits
    localparam int VLE_IMM_W   = 8;    // immediate width
    localparam int VLE_SPEC_W  = 4;    // reserved specifier width
endpackage

// File: rtl/vle_slice_sel.sv
// Slice selector: picks one aligned slice of CHUNK_W or 2*CHUNK_W bits
// from the source. The number of legal positions follows from the source
// and slice widths, and the immediate is reduced modulo that count, so
// higher immediate bits are ignored.
// Assumes N_CHUNK is a power of two and at least 4.
module vle_slice_sel #(
    parameter int VEC_W   = vle_pkg::VLE_VEC_W,
    parameter int CHUNK_W = vle_pkg::VLE_CHUNK_W,
    parameter int IMM_W   = vle_pkg::VLE_IMM_W
) (
    input  logic [VEC_W-1:0]     src_vec,
    input  logic [IMM_W-1:0]     imm,
    input  logic                 src_wide,
    input  logic                 slice_wide,
    output logic [2*CHUNK_W-1:0] slice
);
    localparam int N_CHUNK = VEC_W / CHUNK_W;
    localparam int IDX_W   = $clog2(N_CHUNK);

    logic [CHUNK_W-1:0] chunk [N_CHUNK];
    logic [IDX_W:0]     pos_cnt;
    logic [IDX_W-1:0]   pos_idx;
    logic [IDX_W-1:0]   base_lo;
    logic [IDX_W-1:0]   base_hi;
    logic               unused_imm;

    // Split the source into aligned chunks.
    for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
        assign chunk[c] = src_vec[c*CHUNK_W +: CHUNK_W];
    end

    // Immediate bits above the position index never matter.
    assign unused_imm = ^imm[IMM_W-1:IDX_W];

    // Count the legal positions, reduce the immediate and locate the chunks.
    always_comb begin
        pos_cnt = src_wide ? (IDX_W+1)'(N_CHUNK) : (IDX_W+1)'(N_CHUNK / 2);
        if (slice_wide) begin
            pos_cnt = pos_cnt >> 1;
        end
        pos_idx = imm[IDX_W-1:0] & IDX_W'(pos_cnt - 1'b1);
        base_lo = slice_wide ? IDX_W'(pos_idx << 1) : pos_idx;
        base_hi = base_lo | IDX_W'(1);
    end

    // Assemble the slice; the upper half is used only for wide slices.
    always_comb begin
        slice[CHUNK_W-1:0]         = chunk[base_lo];
        slice[2*CHUNK_W-1:CHUNK_W] = slice_wide ? chunk[base_hi] : '0;
    end
endmodule

// File: rtl/vle_elem_mask.sv
// Element masking: applies the writemask per 32-bit word. Element size
// picks which mask bit governs each word. Register destinations merge or
// zero the masked words and clear the bits above the slice. Memory
// destinations pass the slice through and emit byte enables.
// Assumes MASK_W >= 2*CHUNK_W/WORD_W.
module vle_elem_mask #(
    parameter int VEC_W   = vle_pkg::VLE_VEC_W,
    parameter int CHUNK_W = vle_pkg::VLE_CHUNK_W,
    parameter int WORD_W  = vle_pkg::VLE_WORD_W,
    parameter int MASK_W  = vle_pkg::VLE_MASK_W
) (
    input  logic [2*CHUNK_W-1:0] slice,
    input  logic [2*CHUNK_W-1:0] old_low,
    input  logic [MASK_W-1:0]    kmask,
    input  logic                 slice_wide,
    input  logic                 elem64,
    input  logic                 mask_en,
    input  logic                 zero_mode,
    input  logic                 dst_mem,
    output logic [VEC_W-1:0]     data,
    output logic [VEC_W/8-1:0]   byte_en
);
    localparam int N_WORD     = VEC_W / WORD_W;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int NARROW_WDS = CHUNK_W / WORD_W;
    localparam int WIDE_WDS   = 2 * NARROW_WDS;

    for (genvar w = 0; w < N_WORD; w++) begin : g_word
        if (w < WIDE_WDS) begin : g_slice
            logic in_slice;
            logic mbit;
            logic take;
            logic [WORD_W-1:0] s_wd;
            logic [WORD_W-1:0] o_wd;

            assign s_wd = slice[w*WORD_W +: WORD_W];
            assign o_wd = old_low[w*WORD_W +: WORD_W];

            // Decide whether this word is in the slice and selected by the mask.
            always_comb begin
                in_slice = (w < NARROW_WDS) || slice_wide;
                mbit     = elem64 ? kmask[w/2] : kmask[w];
                take     = !mask_en || mbit;
            end

            // Produce the data word and its byte enables for either destination.
            always_comb begin
                if (!in_slice) begin
                    data[w*WORD_W +: WORD_W] = '0;
                end else if (dst_mem || take) begin
                    data[w*WORD_W +: WORD_W] = s_wd;
                end else begin
                    data[w*WORD_W +: WORD_W] = zero_mode ? '0 : o_wd;
                end
                if (dst_mem) begin
                    byte_en[w*WORD_BYTES +: WORD_BYTES] = {WORD_BYTES{in_slice && take}};
                end else begin
                    byte_en[w*WORD_BYTES +: WORD_BYTES] = '1;
                end
            end
        end else begin : g_upper
            // Words above any slice: zero data, enabled only for registers.
            assign data[w*WORD_W +: WORD_W]              = '0;
            assign byte_en[w*WORD_BYTES +: WORD_BYTES]   = {WORD_BYTES{!dst_mem}};
        end
    end
endmodule

// File: rtl/vle_fault_chk.sv
// Encoding check: flags a reserved specifier other than all ones, a
// legacy encoding with the length bit clear, and a wide slice requested
// from a narrow source.
// Assumes the fields are valid only in the cycle in_valid is high.
module vle_fault_chk #(
    parameter int SPEC_W = vle_pkg::VLE_SPEC_W
) (
    input  logic [SPEC_W-1:0] rsv_spec,
    input  logic              legacy_enc,
    input  logic              vlen_bit,
    input  logic              src_wide,
    input  logic              slice_wide,
    output logic              fault
);
    // Combine the three independent illegal-encoding causes.
    always_comb begin
        fault = (rsv_spec != '1)
             || (legacy_enc && !vlen_bit)
             || (slice_wide && !src_wide);
    end
endmodule

// File: rtl/vec_lane_extract.sv
// Top of the masked lane extract unit. Combines slice selection, element
// masking and the encoding check, then registers the result one clock after
// in_valid. A fault clears all byte enables. The legacy encoding disables
// masking.
// Assumes no backpressure: a result is consumed in the cycle it is valid.
module vec_lane_extract #(
    parameter int VEC_W   = vle_pkg::VLE_VEC_W,
    parameter int CHUNK_W = vle_pkg::VLE_CHUNK_W,
    parameter int WORD_W  = vle_pkg::VLE_WORD_W,
    parameter int MASK_W  = vle_pkg::VLE_MASK_W,
    parameter int IMM_W   = vle_pkg::VLE_IMM_W,
    parameter int SPEC_W  = vle_pkg::VLE_SPEC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 src_wide,
    input  logic                 slice_wide,
    input  logic                 elem64,
    input  logic                 mask_en,
    input  logic                 zero_mode,
    input  logic                 dst_mem,
    input  logic                 legacy_enc,
    input  logic                 vlen_bit,
    input  logic [SPEC_W-1:0]    rsv_spec,
    input  logic [IMM_W-1:0]     imm,
    input  logic [MASK_W-1:0]    kmask,
    input  logic [VEC_W-1:0]     src_vec,
    input  logic [2*CHUNK_W-1:0] old_low,
    output logic                 out_valid,
    output logic                 out_fault,
    output logic [VEC_W-1:0]     out_data,
    output logic [VEC_W/8-1:0]   out_byte_en
);
    localparam int N_BYTE = VEC_W / 8;
    localparam int WIDE_B = 2 * CHUNK_W / 8;

    logic [2*CHUNK_W-1:0] slice;
    logic [VEC_W-1:0]     m_data;
    logic [N_BYTE-1:0]    m_be;
    logic                 fault;
    logic                 mask_eff;

    // The legacy encoding carries no writemask.
    assign mask_eff = mask_en && !legacy_enc;

    vle_slice_sel #(
        .VEC_W(VEC_W), .CHUNK_W(CHUNK_W), .IMM_W(IMM_W)
    ) u_sel (
        .src_vec(src_vec), .imm(imm), .src_wide(src_wide),
        .slice_wide(slice_wide), .slice(slice)
    );

    vle_elem_mask #(
        .VEC_W(VEC_W), .CHUNK_W(CHUNK_W), .WORD_W(WORD_W), .MASK_W(MASK_W)
    ) u_mask (
        .slice(slice), .old_low(old_low), .kmask(kmask),
        .slice_wide(slice_wide), .elem64(elem64), .mask_en(mask_eff),
        .zero_mode(zero_mode), .dst_mem(dst_mem),
        .data(m_data), .byte_en(m_be)
    );

    vle_fault_chk #(
        .SPEC_W(SPEC_W)
    ) u_fault (
        .rsv_spec(rsv_spec), .legacy_enc(legacy_enc), .vlen_bit(vlen_bit),
        .src_wide(src_wide), .slice_wide(slice_wide), .fault(fault)
    );

    // Output stage: capture a valid operation, hold the data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_fault   <= 1'b0;
            out_data    <= '0;
            out_byte_en <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_fault   <= fault;
                out_data    <= m_data;
                out_byte_en <= fault ? '0 : m_be;
            end
        end
    end

    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_byte_en)));

    assert_fault_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault) |-> (out_byte_en == '0));

    assert_fault_spec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsv_spec != '1) |=> out_fault);

    assert_reg_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dst_mem && !slice_wide) |=> (out_data[VEC_W-1:CHUNK_W] == '0));

    assert_mem_upper_be_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_mem) |=> (out_byte_en[N_BYTE-1:WIDE_B] == '0));

    assert_zero_elem_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dst_mem && mask_en && !legacy_enc && zero_mode && !kmask[0])
        |=> (out_data[WORD_W-1:0] == '0));
endmodule

// File: tb/vec_lane_extract_test.sv
module vec_lane_extract_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         src_wide = 1'b0, slice_wide = 1'b0, elem64 = 1'b0;
    logic         mask_en = 1'b0, zero_mode = 1'b0, dst_mem = 1'b0;
    logic         legacy_enc = 1'b0, vlen_bit = 1'b1;
    logic [3:0]   rsv_spec = 4'hF;
    logic [7:0]   imm = '0;
    logic [7:0]   kmask = '0;
    logic [511:0] src_vec;
    logic [255:0] old_low;
    logic         out_valid, out_fault;
    logic [511:0] out_data;
    logic [63:0]  out_byte_en;

    logic [511:0] exp_data;
    logic [63:0]  exp_be;
    logic         exp_fault;
    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    vec_lane_extract uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_wide(src_wide),
        .slice_wide(slice_wide), .elem64(elem64), .mask_en(mask_en),
        .zero_mode(zero_mode), .dst_mem(dst_mem), .legacy_enc(legacy_enc),
        .vlen_bit(vlen_bit), .rsv_spec(rsv_spec), .imm(imm), .kmask(kmask),
        .src_vec(src_vec), .old_low(old_low), .out_valid(out_valid),
        .out_fault(out_fault), .out_data(out_data), .out_byte_en(out_byte_en)
    );

    task automatic check(string tag, string what, logic [511:0] act, logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    task automatic model();
        int nsrc, sch, npos, pos, sw;
        nsrc = src_wide ? 4 : 2;
        sch  = slice_wide ? 2 : 1;
        npos = nsrc / sch;
        pos  = int'(imm) % npos;
        sw   = sch * 4;
        exp_fault = (rsv_spec != 4'hF) || (legacy_enc && !vlen_bit) || (slice_wide && !src_wide);
        for (int w = 0; w < 16; w++) begin
            logic [31:0] s, o;
            logic take;
            if (w < sw) begin
                s = src_vec[(pos*sw + w)*32 +: 32];
                o = old_low[w*32 +: 32];
                take = !mask_en || legacy_enc || kmask[elem64 ? w/2 : w];
                if (dst_mem) begin
                    exp_data[w*32 +: 32] = s;
                    exp_be[w*4 +: 4] = {4{take}};
                end else begin
                    exp_data[w*32 +: 32] = take ? s : (zero_mode ? 32'h0 : o);
                    exp_be[w*4 +: 4] = 4'hF;
                end
            end else begin
                exp_data[w*32 +: 32] = '0;
                exp_be[w*4 +: 4] = {4{!dst_mem}};
            end
        end
        if (exp_fault) exp_be = '0;
    endtask

    // Apply one operation and check its registered result.
    task automatic run(string tag);
        @(negedge clk);
        in_valid = 1'b1;
        model();
        @(posedge clk);
        #1;
        check(tag, "valid", 512'(out_valid), 512'(1'b1));
        check(tag, "fault", 512'(out_fault), 512'(exp_fault));
        check(tag, "byte_en", 512'(out_byte_en), 512'(exp_be));
        if (!exp_fault) check(tag, "data", out_data, exp_data);
    endtask

    task automatic set_mode(logic sw, logic sl, logic e64, logic men, logic zm, logic mem);
        src_wide = sw; slice_wide = sl; elem64 = e64;
        mask_en = men; zero_mode = zm; dst_mem = mem;
        legacy_enc = 1'b0; vlen_bit = 1'b1; rsv_spec = 4'hF;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R12", "reset valid", 512'(out_valid), 512'(0));
        check("R12", "reset fault", 512'(out_fault), 512'(0));
        check("R12", "reset data", out_data, 512'(0));
        check("R12", "reset byte_en", 512'(out_byte_en), 512'(0));
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_sel_narrow_src();
        set_mode(0, 0, 0, 0, 0, 0);
        imm = 8'h00; run("R1");
        imm = 8'h01; run("R1");
        imm = 8'hFE; run("R1");
        imm = 8'hFF; run("R1");
    endtask

    task automatic t_sel_wide_src();
        set_mode(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            imm = 8'(i); run("R2");
        end
        imm = 8'hFE; run("R2");
        imm = 8'h7D; run("R2");
        imm = 8'h01; run("R8");
    endtask

    task automatic t_sel_wide_slice();
        set_mode(1, 1, 0, 0, 0, 0);
        imm = 8'h00; run("R3");
        imm = 8'h01; run("R3");
        imm = 8'hA4; run("R3");
        imm = 8'h5B; run("R8");
    endtask

    task automatic t_mask(logic zm, string tag);
        set_mode(1, 0, 0, 1, zm, 0);
        imm = 8'h02; kmask = 8'hA5; run(tag);
        slice_wide = 1'b1; imm = 8'h01; kmask = 8'h3C; run("R4");
        elem64 = 1'b1; slice_wide = 1'b0; imm = 8'h03; kmask = 8'hF2; run("R4");
        slice_wide = 1'b1; imm = 8'h00; kmask = 8'h09; run(tag);
    endtask

    task automatic t_nomask();
        set_mode(1, 1, 0, 0, 0, 0);
        imm = 8'h01; kmask = 8'h00; run("R5");
        set_mode(0, 0, 0, 1, 1, 0);
        legacy_enc = 1'b1; imm = 8'h01; kmask = 8'h00; run("R5");
    endtask

    task automatic t_mem();
        set_mode(1, 1, 0, 1, 1, 1);
        imm = 8'h01; kmask = 8'h96; run("R9");
        set_mode(1, 0, 1, 1, 1, 1);
        imm = 8'h02; kmask = 8'hF1; run("R9");
        set_mode(0, 0, 0, 0, 1, 1);
        imm = 8'h01; kmask = 8'h00; run("R9");
    endtask

    task automatic t_fault();
        set_mode(1, 0, 0, 0, 0, 1);
        rsv_spec = 4'hE; run("R10");
        set_mode(0, 0, 0, 0, 0, 0);
        legacy_enc = 1'b1; vlen_bit = 1'b0; run("R11");
        set_mode(0, 1, 0, 1, 0, 0);
        kmask = 8'hFF; run("R10");
        set_mode(0, 0, 0, 0, 0, 0);
        legacy_enc = 1'b1; vlen_bit = 1'b1; run("R10");
    endtask

    task automatic t_hold();
        logic [511:0] prev_d;
        logic [63:0]  prev_be;
        set_mode(1, 0, 0, 0, 0, 0);
        imm = 8'h03; run("R12");
        prev_d = out_data;
        prev_be = out_byte_en;
        @(negedge clk);
        in_valid = 1'b0;
        imm = 8'h00;
        src_vec = ~src_vec;
        @(posedge clk);
        #1;
        check("R12", "idle valid", 512'(out_valid), 512'(0));
        check("R12", "idle data", out_data, prev_d);
        check("R12", "idle byte_en", 512'(out_byte_en), 512'(prev_be));
        src_vec = ~src_vec;
    endtask

    initial begin
        for (int w = 0; w < 16; w++) src_vec[w*32 +: 32] = {8'(w), 8'hC3, 8'(w ^ 5), 8'h5A};
        for (int w = 0; w < 8; w++) old_low[w*32 +: 32] = {8'hEE, 8'(w), 8'hDD, 8'(w + 16)};
        t_reset();
        t_sel_narrow_src();
        t_sel_wide_src();
        t_sel_wide_slice();
        t_mask(1'b0, "R6");
        t_mask(1'b1, "R7");
        t_nomask();
        t_mem();
        t_fault();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R12 watchdog: actual hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule